// File: doc/BRIEF.md
# Disk Taskfile Register Front End

This block sits between a host bus and the back end of an ATA-style disk device. It turns a small address space into the eight-bit taskfile registers: feature, sector count, three address bytes, device select and device control. It also returns the device's status and error bytes on reads. Host writes to the taskfile are accepted only while the device says its registers may be loaded. A write to the command address sends a one-cycle issue strobe and the command byte to the back end.

The block keeps the device interrupt as a flag. The back end sets the flag when a command completes. The host clears it by reading the primary status address or by writing an accepted command. The alternate status address returns the same status byte but leaves the flag alone. Accesses to the data address become read and write strobes toward the back end's PIO path. All outputs are registered, so every effect of a host access appears one clock after the access is sampled.

Top module: `ata_regfile_front`

## Requirements
- R1: While reset is held and right after it, the taskfile registers, device control, command strobe, PIO strobes, interrupt and read data are all zero.
- R2: The device is writable when status bit 7 (busy) and status bit 3 (data request) are both clear. Address map: 0 data, 1 feature/error, 2 count, 3 address byte 0, 4 address byte 1, 5 address byte 2, 6 device, 7 command/status, 8 alternate status/device control. A writable write to addresses 1 to 6 stores bits 7:0 of the bus word, and a later read of addresses 2 to 6 returns that byte zero-extended.
- R3: While the device is not writable, writes to addresses 1 to 7 change no taskfile register, raise no command strobe and leave the interrupt unchanged.
- R4: An accepted write to address 7 raises cmd_issue for exactly one cycle with cmd_code equal to bits 7:0 of the bus word, and it clears the interrupt.
- R5: A read of address 7 returns the status input and clears the interrupt.
- R6: A read of address 8 returns the status input and leaves the interrupt unchanged.
- R7: A write to address 8 loads the device control register from bits 7:0, whatever the device state.
- R8: A read of address 1 returns the error input, while a write to address 1 loads the feature register and not the error byte.
- R9: A write to address 0 gives a one-cycle pio_wr with pio_wdata equal to bits 15:0. A read of address 0 gives a one-cycle pio_rd, and the read data is the back end's 16-bit PIO word.
- R10: A be_irq_set pulse sets the interrupt, which then stays high until a clear. When a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 4 | Register address |
| hst_wr | input | 1 | Write access this cycle |
| hst_rd | input | 1 | Read access this cycle |
| hst_wdata | input | 32 | Write data |
| hst_rdata | output | 32 | Read data, registered |
| be_status | input | 8 | Device status byte |
| be_error | input | 8 | Device error byte |
| be_irq_set | input | 1 | Completion pulse that sets the interrupt |
| be_pio_rdata | input | 16 | PIO word returned on data reads |
| tf_feature | output | 8 | Feature register |
| tf_count | output | 8 | Sector count register |
| tf_lba0 | output | 8 | Address byte 0 |
| tf_lba1 | output | 8 | Address byte 1 |
| tf_lba2 | output | 8 | Address byte 2 |
| tf_device | output | 8 | Device select register |
| tf_devctl | output | 8 | Device control register |
| cmd_issue | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Last issued command byte |
| pio_wr | output | 1 | PIO write strobe |
| pio_rd | output | 1 | PIO read strobe |
| pio_wdata | output | 16 | PIO write word |
| irq | output | 1 | Device interrupt level |

## Verification
The bench writes distinct byte patterns to each taskfile address with junk in the upper bus bits. This shows that only the low byte is kept and that no two addresses alias. The same writes are then repeated with busy set and with data request set, so each gating bit is shown to block writes on its own. The interrupt is raised and then read through the alternate and the primary status addresses, so the clearing read can be told apart from the one that does not clear. A command write is tried both accepted and refused, and a set is made to collide with a clearing read to confirm that the set wins.

// File: rtl/ata_fe_pkg.sv
package ata_fe_pkg;
    localparam int TF_W   = 8;
    localparam int ADDR_W = 4;
    localparam int ST_BSY = 7;
    localparam int ST_DRQ = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA  = 4'd0,
        A_FEAT  = 4'd1,
        A_COUNT = 4'd2,
        A_LBA0  = 4'd3,
        A_LBA1  = 4'd4,
        A_LBA2  = 4'd5,
        A_DEV   = 4'd6,
        A_CMD   = 4'd7,
        A_ALT   = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [TF_W-1:0] feature;
        logic [TF_W-1:0] count;
        logic [TF_W-1:0] lba0;
        logic [TF_W-1:0] lba1;
        logic [TF_W-1:0] lba2;
        logic [TF_W-1:0] device;
        logic [TF_W-1:0] devctl;
    } taskfile_t;
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TF_W-1:0]   wbyte,
    input  logic              writable,
    output taskfile_t         tf,
    output logic              issue,
    output logic [TF_W-1:0]   code
);
    typedef struct packed {
        taskfile_t       tf;
        logic            issue;
        logic [TF_W-1:0] code;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.issue = 1'b0;
        if (wr_en) begin
            if (addr == A_ALT) begin
                st_d.tf.devctl = wbyte;
            end else if (writable) begin
                case (addr)
                    A_FEAT:  st_d.tf.feature = wbyte;
                    A_COUNT: st_d.tf.count   = wbyte;
                    A_LBA0:  st_d.tf.lba0    = wbyte;
                    A_LBA1:  st_d.tf.lba1    = wbyte;
                    A_LBA2:  st_d.tf.lba2    = wbyte;
                    A_DEV:   st_d.tf.device  = wbyte;
                    A_CMD: begin
                        st_d.issue = 1'b1;
                        st_d.code  = wbyte;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tf    = st_q.tf;
    assign issue = st_q.issue;
    assign code  = st_q.code;

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !writable && addr != A_ALT) |=>
        ($stable({tf.feature, tf.count, tf.lba0, tf.lba1, tf.lba2, tf.device}) && !issue)); // R3
    AST_ISSUE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && writable && addr == A_CMD) |=> (issue && code == $past(wbyte))); // R4
endmodule

// File: rtl/ata_irq_ctl.sv
module ata_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set)      st_d.flag = 1'b1;
        else if (clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag); // R10
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set) |=> $stable(flag)); // R10
endmodule

// File: rtl/ata_rd_port.sv
module ata_rd_port
    import ata_fe_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int PIO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  taskfile_t         tf,
    input  logic [TF_W-1:0]   status,
    input  logic [TF_W-1:0]   error,
    input  logic [PIO_W-1:0]  pio_word,
    output logic [BUS_W-1:0]  rdata
);
    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;
    logic [TF_W-1:0] byte_sel;

    always_comb begin
        case (addr)
            A_FEAT:  byte_sel = error;
            A_COUNT: byte_sel = tf.count;
            A_LBA0:  byte_sel = tf.lba0;
            A_LBA1:  byte_sel = tf.lba1;
            A_LBA2:  byte_sel = tf.lba2;
            A_DEV:   byte_sel = tf.device;
            A_CMD:   byte_sel = status;
            A_ALT:   byte_sel = status;
            default: byte_sel = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rdata = '0;
            if (addr == A_DATA) st_d.rdata[PIO_W-1:0] = pio_word;
            else                st_d.rdata[TF_W-1:0]  = byte_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == A_CMD || addr == A_ALT)) |=> (rdata == BUS_W'($past(status)))); // R5
endmodule

// File: rtl/ata_pio_pass.sv
module ata_pio_pass
    import ata_fe_pkg::*;
#(
    parameter int PIO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PIO_W-1:0]  wword,
    output logic              pio_wr,
    output logic              pio_rd,
    output logic [PIO_W-1:0]  pio_wdata
);
    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [PIO_W-1:0] wdata;
    } st_t;

    st_t st_d, st_q;
    logic hit;

    assign hit = (addr == A_DATA);

    always_comb begin
        st_d    = st_q;
        st_d.wr = wr_en && hit;
        st_d.rd = rd_en && hit;
        if (wr_en && hit) st_d.wdata = wword;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pio_wr    = st_q.wr;
    assign pio_rd    = st_q.rd;
    assign pio_wdata = st_q.wdata;

    AST_PIO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit || (!wr_en && !rd_en)) |=> (!pio_wr && !pio_rd)); // R9
endmodule

// File: rtl/ata_regfile_front.sv
module ata_regfile_front
    import ata_fe_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int PIO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic [BUS_W-1:0]  hst_wdata,
    output logic [BUS_W-1:0]  hst_rdata,
    input  logic [TF_W-1:0]   be_status,
    input  logic [TF_W-1:0]   be_error,
    input  logic              be_irq_set,
    input  logic [PIO_W-1:0]  be_pio_rdata,
    output logic [TF_W-1:0]   tf_feature,
    output logic [TF_W-1:0]   tf_count,
    output logic [TF_W-1:0]   tf_lba0,
    output logic [TF_W-1:0]   tf_lba1,
    output logic [TF_W-1:0]   tf_lba2,
    output logic [TF_W-1:0]   tf_device,
    output logic [TF_W-1:0]   tf_devctl,
    output logic              cmd_issue,
    output logic [TF_W-1:0]   cmd_code,
    output logic              pio_wr,
    output logic              pio_rd,
    output logic [PIO_W-1:0]  pio_wdata,
    output logic              irq
);
    taskfile_t tf;
    logic      writable;
    logic      irq_clr;
    logic      unused_hi;

    assign writable  = !be_status[ST_BSY] && !be_status[ST_DRQ];
    assign irq_clr   = (hst_rd && hst_addr == A_CMD) ||
                       (hst_wr && hst_addr == A_CMD && writable);
    assign unused_hi = ^hst_wdata[BUS_W-1:PIO_W];

    ata_tf_regs u_tf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hst_wr),
        .addr     (hst_addr),
        .wbyte    (hst_wdata[TF_W-1:0]),
        .writable (writable),
        .tf       (tf),
        .issue    (cmd_issue),
        .code     (cmd_code)
    );

    ata_irq_ctl u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (be_irq_set),
        .clr   (irq_clr),
        .flag  (irq)
    );

    ata_rd_port #(.BUS_W(BUS_W), .PIO_W(PIO_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (hst_rd),
        .addr     (hst_addr),
        .tf       (tf),
        .status   (be_status),
        .error    (be_error),
        .pio_word (be_pio_rdata),
        .rdata    (hst_rdata)
    );

    ata_pio_pass #(.PIO_W(PIO_W)) u_pio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hst_wr),
        .rd_en     (hst_rd),
        .addr      (hst_addr),
        .wword     (hst_wdata[PIO_W-1:0]),
        .pio_wr    (pio_wr),
        .pio_rd    (pio_rd),
        .pio_wdata (pio_wdata)
    );

    assign tf_feature = tf.feature;
    assign tf_count   = tf.count;
    assign tf_lba0    = tf.lba0;
    assign tf_lba1    = tf.lba1;
    assign tf_lba2    = tf.lba2;
    assign tf_device  = tf.device;
    assign tf_devctl  = tf.devctl;

    AST_REFUSED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && hst_addr == A_CMD && !writable && !hst_rd && !be_irq_set) |=>
        (!cmd_issue && $stable(irq))); // R3
    AST_ALT_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && hst_rd && hst_addr == A_ALT && !hst_wr) |=> irq); // R6
    AST_DEVCTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && hst_addr == A_ALT) |=> (tf_devctl == $past(hst_wdata[TF_W-1:0]))); // R7
endmodule

// File: tb/tb_ata_regfile_front.sv
`timescale 1ns/1ps
module tb_ata_regfile_front;
    localparam int BUS_W = 32;
    localparam int PIO_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        hst_addr = '0;
    logic              hst_wr = 1'b0;
    logic              hst_rd = 1'b0;
    logic [BUS_W-1:0]  hst_wdata = '0;
    logic [BUS_W-1:0]  hst_rdata;
    logic [7:0]        be_status = 8'h50;
    logic [7:0]        be_error = '0;
    logic              be_irq_set = 1'b0;
    logic [PIO_W-1:0]  be_pio_rdata = '0;
    logic [7:0]        tf_feature, tf_count, tf_lba0, tf_lba1, tf_lba2, tf_device, tf_devctl;
    logic              cmd_issue, pio_wr, pio_rd, irq;
    logic [7:0]        cmd_code;
    logic [PIO_W-1:0]  pio_wdata;

    ata_regfile_front #(.BUS_W(BUS_W), .PIO_W(PIO_W)) dut (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .be_status(be_status),
        .be_error(be_error), .be_irq_set(be_irq_set), .be_pio_rdata(be_pio_rdata),
        .tf_feature(tf_feature), .tf_count(tf_count), .tf_lba0(tf_lba0), .tf_lba1(tf_lba1),
        .tf_lba2(tf_lba2), .tf_device(tf_device), .tf_devctl(tf_devctl),
        .cmd_issue(cmd_issue), .cmd_code(cmd_code), .pio_wr(pio_wr), .pio_rd(pio_rd),
        .pio_wdata(pio_wdata), .irq(irq)
    );

    always #4 clk = ~clk;

    typedef enum int {S_RDATA, S_IRQ, S_ISSUE, S_CODE, S_FEAT, S_COUNT, S_LBA0,
                      S_LBA2, S_DEV, S_DEVCTL, S_PIOWR, S_PIORD, S_PIOWD} sel_e;
    typedef struct {
        int    due;
        sel_e  sel;
        int    exp;
        string tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int actual(sel_e s);
        case (s)
            S_RDATA:  return int'(hst_rdata);
            S_IRQ:    return int'(irq);
            S_ISSUE:  return int'(cmd_issue);
            S_CODE:   return int'(cmd_code);
            S_FEAT:   return int'(tf_feature);
            S_COUNT:  return int'(tf_count);
            S_LBA0:   return int'(tf_lba0);
            S_LBA2:   return int'(tf_lba2);
            S_DEV:    return int'(tf_device);
            S_DEVCTL: return int'(tf_devctl);
            S_PIOWR:  return int'(pio_wr);
            S_PIORD:  return int'(pio_rd);
            default:  return int'(pio_wdata);
        endcase
    endfunction

    // monitor: compares queued expectations once their cycle has come
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            int    a;
            it = q.pop_front();
            a  = actual(it.sel);
            n_chk++;
            if (a !== it.exp) begin
                n_fail++;
                $display("FAIL %s %s: actual %0h expected %0h", it.tag, it.sel.name(), a, it.exp);
            end
        end
    end

    // expectation on the outputs right after the next active edge
    task automatic expect_v(sel_e s, int v, string tag);
        item_t it;
        it.due = cyc + 1; it.sel = s; it.exp = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic op(bit w, bit r, logic [3:0] a, logic [31:0] d, bit s);
        @(negedge clk);
        hst_wr = w; hst_rd = r; hst_addr = a; hst_wdata = d; be_irq_set = s;
    endtask

    task automatic idle();
        op(0, 0, 4'd0, 32'h0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        expect_v(S_IRQ, 0, "R1"); expect_v(S_ISSUE, 0, "R1"); expect_v(S_FEAT, 0, "R1");
        expect_v(S_DEVCTL, 0, "R1"); expect_v(S_RDATA, 0, "R1"); expect_v(S_PIOWR, 0, "R1");
        @(negedge clk); rst_n = 1'b1;
        // R2 R8: writable writes keep the low byte
        op(1, 0, 4'd1, 32'hABCD_FF12, 0); expect_v(S_FEAT, 8'h12, "R8");
        op(1, 0, 4'd2, 32'h7700_0034, 0); expect_v(S_COUNT, 8'h34, "R2");
        op(1, 0, 4'd3, 32'h0000_1156, 0); expect_v(S_LBA0, 8'h56, "R2");
        op(1, 0, 4'd4, 32'h0000_0078, 0);
        op(1, 0, 4'd5, 32'hFFFF_FF9A, 0); expect_v(S_LBA2, 8'h9A, "R2");
        op(1, 0, 4'd6, 32'h0000_00E0, 0); expect_v(S_DEV, 8'hE0, "R2");
        op(0, 1, 4'd2, 32'h0, 0); expect_v(S_RDATA, 32'h34, "R2");
        op(0, 1, 4'd4, 32'h0, 0); expect_v(S_RDATA, 32'h78, "R2");
        op(0, 1, 4'd6, 32'h0, 0); expect_v(S_RDATA, 32'hE0, "R2");
        // R8: error on read, feature untouched
        be_error = 8'h04;
        op(0, 1, 4'd1, 32'h0, 0); expect_v(S_RDATA, 32'h04, "R8"); expect_v(S_FEAT, 8'h12, "R8");
        // R10 R6 R5
        op(0, 0, 4'd0, 32'h0, 1); expect_v(S_IRQ, 1, "R10");
        idle(); expect_v(S_IRQ, 1, "R10");
        op(0, 1, 4'd8, 32'h0, 0); expect_v(S_RDATA, 32'h50, "R6"); expect_v(S_IRQ, 1, "R6");
        op(0, 1, 4'd7, 32'h0, 0); expect_v(S_RDATA, 32'h50, "R5"); expect_v(S_IRQ, 0, "R5");
        // R4: accepted command
        op(0, 0, 4'd0, 32'h0, 1);
        op(1, 0, 4'd7, 32'h1234_56EC, 0);
        expect_v(S_ISSUE, 1, "R4"); expect_v(S_CODE, 8'hEC, "R4"); expect_v(S_IRQ, 0, "R4");
        idle(); expect_v(S_ISSUE, 0, "R4");
        // R3: busy blocks writes and commands
        be_status = 8'h80;
        op(1, 0, 4'd2, 32'h11, 0); expect_v(S_COUNT, 8'h34, "R3");
        op(0, 0, 4'd0, 32'h0, 1);
        op(1, 0, 4'd7, 32'h20, 0); expect_v(S_ISSUE, 0, "R3"); expect_v(S_IRQ, 1, "R3");
        expect_v(S_CODE, 8'hEC, "R3");
        // R3: data request alone blocks too
        be_status = 8'h58;
        op(1, 0, 4'd3, 32'h22, 0); expect_v(S_LBA0, 8'h56, "R3");
        op(1, 0, 4'd1, 32'h33, 0); expect_v(S_FEAT, 8'h12, "R3");
        // R7: device control not gated
        op(1, 0, 4'd8, 32'hFF02, 0); expect_v(S_DEVCTL, 8'h02, "R7");
        op(0, 1, 4'd8, 32'h0, 0); expect_v(S_RDATA, 32'h58, "R6"); expect_v(S_IRQ, 1, "R6");
        // R9: data port
        be_status = 8'h58; be_pio_rdata = 16'hBEEF;
        op(1, 0, 4'd0, 32'h1234_ABCD, 0);
        expect_v(S_PIOWR, 1, "R9"); expect_v(S_PIOWD, 16'hABCD, "R9"); expect_v(S_PIORD, 0, "R9");
        op(0, 1, 4'd0, 32'h0, 0);
        expect_v(S_PIORD, 1, "R9"); expect_v(S_RDATA, 32'hBEEF, "R9"); expect_v(S_PIOWR, 0, "R9");
        idle(); expect_v(S_PIORD, 0, "R9");
        // R10: set beats a clearing read in the same cycle
        be_status = 8'h50;
        op(0, 1, 4'd7, 32'h0, 0); expect_v(S_IRQ, 0, "R5");
        op(0, 1, 4'd7, 32'h0, 1); expect_v(S_IRQ, 1, "R10");
        idle(); expect_v(S_IRQ, 1, "R10");
        idle(); idle();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule